// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block guards a battery-backed byte-wide memory against corruption while its supply is unstable. It takes two digital comparator flags: one says the supply sits above the write-protect threshold, the other says it sits above the lower battery-switchover level. From them it produces a write-protect signal, a request to tri-state the memory data outputs, a battery-select signal and a persistent battery-armed bit. Chip-enable and write-enable pass through to the array only in normal operation. In every other state both are forced inactive (high).

Both flags are resynchronised and debounced before the state machine reacts to them. A supply failure locks the memory out within a few cycles. A supply that has returned must stay valid for a long recovery interval before writes are allowed again. The battery starts out sealed and is armed by the first valid supply. Before that, losing the supply never selects the battery. An ordinary reset leaves the armed bit alone; only the dedicated seal-clear input clears it.

Five states exist, reported on `state_o`: SEALED, NORMAL, PROTECT_RECOVER, PROTECT_FAIL and ON_BATTERY. The transitions, with "valid" meaning the filtered write-protect flag is high and "above" meaning the filtered switchover flag is high:

- SEALED to PROTECT_RECOVER when valid (arming).
- SEALED to PROTECT_FAIL when armed, not valid and above.
- SEALED to ON_BATTERY when armed, not valid and not above.
- NORMAL to PROTECT_FAIL on loss of valid while above.
- NORMAL to ON_BATTERY on loss of valid while not above.
- PROTECT_RECOVER to PROTECT_FAIL or ON_BATTERY on loss of valid, chosen the same way as from NORMAL.
- PROTECT_RECOVER to NORMAL once the recovery count expires.
- PROTECT_FAIL to ON_BATTERY when not above.
- PROTECT_FAIL to PROTECT_RECOVER when valid.
- ON_BATTERY to PROTECT_RECOVER when above and valid.
- ON_BATTERY to PROTECT_FAIL when above and not valid.

Top module: `pfail_supervisor`

## Requirements
- R1: While `rst_n` or `seal_clr_n` is low, `state_o` is SEALED (code 0), and `wprot` and `out_hiz_req` are 1, and `batt_sel` is 0. Asserting `seal_clr_n` also clears `batt_armed` to 0.
- R2: With `LOW_RANGE`=0 only `vcc_ok_hi` is used as the supply-valid flag and `vcc_ok_lo` has no effect; with `LOW_RANGE`=1 the roles swap.
- R3: Each flag passes through two synchronising flops. A new level is then acted on only after `FILT_LEN` consecutive equal synchronised samples, so a pulse shorter than `FILT_LEN` cycles changes neither state nor `batt_armed`.
- R4: The first filtered supply-valid sets `batt_armed` to 1 and moves SEALED to PROTECT_RECOVER (code 2).
- R5: PROTECT_RECOVER lasts exactly `RECOVER_CYC` cycles of continuous supply-valid and then enters NORMAL (code 1).
- R6: A filtered loss of supply-valid during PROTECT_RECOVER leaves that state. The next recovery count starts again from zero.
- R7: `wprot` and `out_hiz_req` are 1 in every state except NORMAL. In NORMAL, `ce_n_out`/`we_n_out` follow `ce_n_in`/`we_n_in`; otherwise both are 1.
- R8: A loss of supply-valid in NORMAL while the switchover flag is high enters PROTECT_FAIL (code 3). Write protection is raised no later than `FAIL_BUDGET_CYC` cycles after the raw flag drops.
- R9: While armed, a filtered low switchover flag enters ON_BATTERY (code 4) with `batt_sel`=1. A high switchover flag leaves it, to PROTECT_RECOVER if supply-valid is also high and to PROTECT_FAIL otherwise.
- R10: While `batt_armed` is 0 the block stays SEALED and `batt_sel` stays 0 whatever the switchover flag does.
- R11: `rst_n` does not change `batt_armed`; only `seal_clr_n` low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of state and filters |
| seal_clr_n | input | 1 | Active-low test input: clears the armed bit and returns to SEALED |
| vcc_ok_hi | input | 1 | Comparator: supply above the higher write-protect threshold |
| vcc_ok_lo | input | 1 | Comparator: supply above the lower write-protect threshold |
| vcc_above_sw | input | 1 | Comparator: supply above the battery-switchover level |
| ce_n_in | input | 1 | Chip-enable from the host, active low |
| we_n_in | input | 1 | Write-enable from the host, active low |
| ce_n_out | output | 1 | Chip-enable to the array, active low |
| we_n_out | output | 1 | Write-enable to the array, active low |
| wprot | output | 1 | Write protection active |
| out_hiz_req | output | 1 | Request to tri-state the memory data outputs |
| batt_sel | output | 1 | Battery path selected |
| batt_armed | output | 1 | Battery backup armed (seal broken) |
| state_o | output | 3 | State code: 0 SEALED, 1 NORMAL, 2 PROTECT_RECOVER, 3 PROTECT_FAIL, 4 ON_BATTERY |

## Verification
The bench builds the block with `LOW_RANGE`=0, `FILT_LEN`=3 and `RECOVER_CYC`=40. The 40-cycle recovery makes the full recovery window, its expiry and its restart reachable in a short run. A filter depth of 3 makes a two-cycle glitch shorter than the filter window, so the rejection case can be driven. The unused lower-threshold flag is toggled to show that it has no effect. Both the ordinary reset and the seal-clear input are pulsed after arming.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        ST_SEALED  = 3'd0,
        ST_NORMAL  = 3'd1,
        ST_RECOVER = 3'd2,
        ST_FAIL    = 3'd3,
        ST_BATTERY = 3'd4
    } pfs_state_e;

endpackage

// File: rtl/pfs_flag_filter.sv
// Two-flop resynchroniser followed by an N-sample agreement filter.
module pfs_flag_filter #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);

    logic sync1;
    logic sync2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    generate
        if (FILT_LEN <= 1) begin : g_bypass
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) filt <= 1'b0;
                else        filt <= sync2;
            end
        end else begin : g_window
            localparam int HW = FILT_LEN - 1;
            logic [HW-1:0]       hist;
            logic [FILT_LEN-1:0] win;

            assign win = {hist, sync2};

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist <= '0;
                    filt <= 1'b0;
                end else begin
                    hist <= win[HW-1:0];
                    if (&win)       filt <= 1'b1;
                    else if (~|win) filt <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pfs_recovery_timer.sv
// Counts cycles while active; done marks the last cycle of the window.
module pfs_recovery_timer #(
    parameter int RECOVER_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);

    localparam int CW = $clog2(RECOVER_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(RECOVER_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!active) cnt <= '0;
        else if (!done)   cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/pfs_seal_latch.sv
// Sticky arming bit; only the seal-clear input returns it to zero.
module pfs_seal_latch (
    input  logic clk,
    input  logic seal_clr_n,
    input  logic arm_req,
    output logic armed
);

    always_ff @(posedge clk or negedge seal_clr_n) begin
        if (!seal_clr_n)  armed <= 1'b0;
        else if (arm_req) armed <= 1'b1;
    end

endmodule

// File: rtl/pfail_supervisor.sv
module pfail_supervisor
    import pfs_pkg::*;
#(
    parameter bit LOW_RANGE       = 1'b0,
    parameter int FILT_LEN        = 2,
    parameter int RECOVER_CYC     = 25_000_000,
    parameter int FAIL_BUDGET_CYC = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seal_clr_n,
    input  logic       vcc_ok_hi,
    input  logic       vcc_ok_lo,
    input  logic       vcc_above_sw,
    input  logic       ce_n_in,
    input  logic       we_n_in,
    output logic       ce_n_out,
    output logic       we_n_out,
    output logic       wprot,
    output logic       out_hiz_req,
    output logic       batt_sel,
    output logic       batt_armed,
    output logic [2:0] state_o
);

    pfs_state_e state;
    pfs_state_e state_nxt;
    logic       ok_raw;
    logic       ok_f;
    logic       sw_f;
    logic       rec_done;
    logic       core_rst_n;

    assign core_rst_n = rst_n & seal_clr_n;
    assign ok_raw     = LOW_RANGE ? vcc_ok_lo : vcc_ok_hi;

    pfs_flag_filter #(.FILT_LEN(FILT_LEN)) u_ok_filt (
        .clk (clk),
        .rst_n (rst_n),
        .raw (ok_raw),
        .filt (ok_f)
    );

    pfs_flag_filter #(.FILT_LEN(FILT_LEN)) u_sw_filt (
        .clk (clk),
        .rst_n (rst_n),
        .raw (vcc_above_sw),
        .filt (sw_f)
    );

    pfs_recovery_timer #(.RECOVER_CYC(RECOVER_CYC)) u_rec_timer (
        .clk (clk),
        .rst_n (core_rst_n),
        .active (state == ST_RECOVER),
        .done (rec_done)
    );

    pfs_seal_latch u_seal (
        .clk (clk),
        .seal_clr_n (seal_clr_n),
        .arm_req (ok_f),
        .armed (batt_armed)
    );

    // State register
    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) state <= ST_SEALED;
        else             state <= state_nxt;
    end

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SEALED: begin
                if (ok_f)            state_nxt = ST_RECOVER;
                else if (batt_armed) state_nxt = sw_f ? ST_FAIL : ST_BATTERY;
            end
            ST_NORMAL: begin
                if (!ok_f)           state_nxt = sw_f ? ST_FAIL : ST_BATTERY;
            end
            ST_RECOVER: begin
                if (!ok_f)           state_nxt = sw_f ? ST_FAIL : ST_BATTERY;
                else if (rec_done)   state_nxt = ST_NORMAL;
            end
            ST_FAIL: begin
                if (!sw_f)           state_nxt = ST_BATTERY;
                else if (ok_f)       state_nxt = ST_RECOVER;
            end
            ST_BATTERY: begin
                if (sw_f)            state_nxt = ok_f ? ST_RECOVER : ST_FAIL;
            end
            default:                 state_nxt = ST_SEALED;
        endcase
    end

    // Outputs
    always_comb begin
        wprot       = 1'b1;
        out_hiz_req = 1'b1;
        batt_sel    = 1'b0;
        ce_n_out    = 1'b1;
        we_n_out    = 1'b1;
        unique case (state)
            ST_NORMAL: begin
                wprot       = 1'b0;
                out_hiz_req = 1'b0;
                ce_n_out    = ce_n_in;
                we_n_out    = we_n_in;
            end
            ST_BATTERY: batt_sel = 1'b1;
            ST_SEALED, ST_RECOVER, ST_FAIL: ;
            default: ;
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
    import pfs_pkg::*;
#(
    parameter bit LOW_RANGE       = 1'b0,
    parameter int RECOVER_CYC     = 25_000_000,
    parameter int FAIL_BUDGET_CYC = 300
) (
    input logic       clk,
    input logic       rst_n,
    input logic       seal_clr_n,
    input logic       vcc_ok_hi,
    input logic       vcc_ok_lo,
    input logic       wprot,
    input logic       batt_sel,
    input logic       batt_armed,
    input logic [2:0] state_o
);

    logic core_rst_n;
    logic ok_sel;
    int   rec_run;
    int   fail_run;

    assign core_rst_n = rst_n & seal_clr_n;
    assign ok_sel     = LOW_RANGE ? vcc_ok_lo : vcc_ok_hi;

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            rec_run  <= 0;
            fail_run <= 0;
        end else begin
            rec_run  <= (state_o == 3'(ST_RECOVER)) ? rec_run + 1 : 0;
            fail_run <= (!ok_sel && !wprot) ? fail_run + 1 : 0;
        end
    end

    AST_RECOVER_FULL: assert property (@(posedge clk) disable iff (!core_rst_n)
        (state_o == 3'(ST_NORMAL) && rec_run != 0) |-> rec_run == RECOVER_CYC); // R5

    AST_RECOVER_EXIT: assert property (@(posedge clk) disable iff (!core_rst_n)
        (state_o == 3'(ST_RECOVER) && rec_run == RECOVER_CYC - 1) |=> state_o != 3'(ST_RECOVER)); // R5

    AST_FAIL_BUDGET: assert property (@(posedge clk) disable iff (!core_rst_n)
        fail_run < FAIL_BUDGET_CYC); // R8

    AST_BATT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!core_rst_n)
        batt_sel |-> batt_armed); // R10

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!seal_clr_n)
        batt_armed |=> batt_armed); // R11

    AST_RECOVER_ARMED: assert property (@(posedge clk) disable iff (!core_rst_n)
        state_o == 3'(ST_RECOVER) |-> batt_armed); // R4

    AST_LEAVE_BATT_PROT: assert property (@(posedge clk) disable iff (!core_rst_n)
        $fell(batt_sel) |-> wprot); // R9

endmodule

bind pfail_supervisor pfs_checker #(
    .LOW_RANGE       (LOW_RANGE),
    .RECOVER_CYC     (RECOVER_CYC),
    .FAIL_BUDGET_CYC (FAIL_BUDGET_CYC)
) u_pfs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .seal_clr_n (seal_clr_n),
    .vcc_ok_hi  (vcc_ok_hi),
    .vcc_ok_lo  (vcc_ok_lo),
    .wprot      (wprot),
    .batt_sel   (batt_sel),
    .batt_armed (batt_armed),
    .state_o    (state_o)
);

// File: tb/test_pfail_supervisor.sv
`timescale 1ns/1ps
module test_pfail_supervisor;

    localparam int FL = 3;
    localparam int RC = 40;
    localparam int S_SEALED = 0, S_NORMAL = 1, S_REC = 2, S_FAIL = 3, S_BATT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, seal_clr_n = 1'b0;
    logic vcc_ok_hi = 1'b0, vcc_ok_lo = 1'b0, vcc_above_sw = 1'b0;
    logic ce_n_in = 1'b1, we_n_in = 1'b1;
    logic ce_n_out, we_n_out, wprot, out_hiz_req, batt_sel, batt_armed;
    logic [2:0] state_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfail_supervisor #(
        .LOW_RANGE(1'b0), .FILT_LEN(FL), .RECOVER_CYC(RC), .FAIL_BUDGET_CYC(300)
    ) i_pfail_supervisor (
        .clk(clk), .rst_n(rst_n), .seal_clr_n(seal_clr_n),
        .vcc_ok_hi(vcc_ok_hi), .vcc_ok_lo(vcc_ok_lo), .vcc_above_sw(vcc_above_sw),
        .ce_n_in(ce_n_in), .we_n_in(we_n_in), .ce_n_out(ce_n_out), .we_n_out(we_n_out),
        .wprot(wprot), .out_hiz_req(out_hiz_req), .batt_sel(batt_sel),
        .batt_armed(batt_armed), .state_o(state_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit q_ok[$];
    bit q_sw[$];
    bit m_fok = 0, m_fsw = 0, m_armed = 0;
    int m_state = S_SEALED, m_cnt = 0;

    function automatic bit agree(ref bit q[$], input bit cur);
        bit res = cur;
        int n = q.size();
        if (q[n-2] == q[n-1-FL]) begin
            res = q[n-2];
            for (int k = 2; k <= FL + 1; k++)
                if (q[n-k] != q[n-2]) res = cur;
        end
        return res;
    endfunction

    initial begin
        for (int k = 0; k < FL + 2; k++) begin
            q_ok.push_back(1'b0);
            q_sw.push_back(1'b0);
        end
    end

    always @(posedge clk) begin
        bit o_ok, o_sw;
        int nxt;
        o_ok = m_fok;
        o_sw = m_fsw;
        if (!rst_n) begin
            for (int k = 0; k < q_ok.size(); k++) begin
                q_ok[k] = 1'b0;
                q_sw[k] = 1'b0;
            end
            m_fok = 0;
            m_fsw = 0;
        end else begin
            m_fok = agree(q_ok, m_fok);
            m_fsw = agree(q_sw, m_fsw);
            q_ok.push_back(vcc_ok_hi); void'(q_ok.pop_front());
            q_sw.push_back(vcc_above_sw); void'(q_sw.pop_front());
        end
        if (!seal_clr_n) m_armed = 0;
        if (!rst_n || !seal_clr_n) begin
            m_state = S_SEALED;
            m_cnt = 0;
        end else begin
            nxt = m_state;
            case (m_state)
                S_SEALED: if (o_ok) nxt = S_REC;
                          else if (m_armed) nxt = o_sw ? S_FAIL : S_BATT;
                S_NORMAL: if (!o_ok) nxt = o_sw ? S_FAIL : S_BATT;
                S_REC:    if (!o_ok) nxt = o_sw ? S_FAIL : S_BATT;
                          else if (m_cnt == RC - 1) nxt = S_NORMAL;
                S_FAIL:   if (!o_sw) nxt = S_BATT; else if (o_ok) nxt = S_REC;
                default:  if (o_sw) nxt = o_ok ? S_REC : S_FAIL;
            endcase
            m_cnt = (m_state == S_REC && nxt == S_REC) ? m_cnt + 1 : 0;
            m_state = nxt;
            if (o_ok) m_armed = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && seal_clr_n && !done) begin
            int tag_st;
            tag_st = m_state;
            case (tag_st)
                S_SEALED: chk("R10 state", int'(state_o), m_state);
                S_NORMAL: chk("R7 state", int'(state_o), m_state);
                S_REC:    chk("R5 state", int'(state_o), m_state);
                S_FAIL:   chk("R8 state", int'(state_o), m_state);
                default:  chk("R9 state", int'(state_o), m_state);
            endcase
            chk("R7 wprot", int'(wprot), int'(m_state != S_NORMAL));
            chk("R7 out_hiz_req", int'(out_hiz_req), int'(m_state != S_NORMAL));
            chk("R7 ce_n_out", int'(ce_n_out), (m_state != S_NORMAL) ? 1 : int'(ce_n_in));
            chk("R7 we_n_out", int'(we_n_out), (m_state != S_NORMAL) ? 1 : int'(we_n_in));
            chk("R9 batt_sel", int'(batt_sel), int'(m_state == S_BATT));
            chk("R11 batt_armed", int'(batt_armed), int'(m_armed));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        step(3);
        chk("R1 state in reset", int'(state_o), S_SEALED);
        chk("R1 wprot in reset", int'(wprot), 1);
        chk("R1 hiz in reset", int'(out_hiz_req), 1);
        chk("R1 batt_sel in reset", int'(batt_sel), 0);
        chk("R1 armed cleared", int'(batt_armed), 0);
        rst_n = 1'b1; seal_clr_n = 1'b1;
        step(20);
        chk("R10 sealed, supply low", int'(state_o), S_SEALED);
        chk("R10 no battery while sealed", int'(batt_sel), 0);
        vcc_above_sw = 1'b1; vcc_ok_lo = 1'b1;
        step(20);
        chk("R2 unused flag ignored", int'(state_o), S_SEALED);
        chk("R2 unused flag no arm", int'(batt_armed), 0);
        vcc_ok_hi = 1'b1; step(2); vcc_ok_hi = 1'b0;
        step(15);
        chk("R3 short pulse rejected", int'(state_o), S_SEALED);
        chk("R3 short pulse no arm", int'(batt_armed), 0);
        vcc_ok_hi = 1'b1;
        step(10);
        chk("R4 armed on first valid", int'(batt_armed), 1);
        chk("R4 recovering", int'(state_o), S_REC);
        step(40);
        chk("R5 normal after recovery", int'(state_o), S_NORMAL);
        ce_n_in = 1'b0; we_n_in = 1'b0;
        step(1);
        chk("R7 ce passes", int'(ce_n_out), 0);
        chk("R7 we passes", int'(we_n_out), 0);
        vcc_ok_hi = 1'b0; step(2); vcc_ok_hi = 1'b1;
        step(10);
        chk("R3 glitch in normal ignored", int'(state_o), S_NORMAL);
        vcc_ok_hi = 1'b0;
        step(8);
        chk("R8 fail state", int'(state_o), S_FAIL);
        chk("R8 ce forced off", int'(ce_n_out), 1);
        vcc_ok_hi = 1'b1;
        step(25);
        chk("R6 recovering", int'(state_o), S_REC);
        vcc_ok_hi = 1'b0;
        step(5);
        vcc_ok_hi = 1'b1;
        step(30);
        chk("R6 count restarted", int'(state_o), S_REC);
        step(25);
        chk("R6 normal after restart", int'(state_o), S_NORMAL);
        vcc_ok_hi = 1'b0; vcc_above_sw = 1'b0;
        step(10);
        chk("R9 on battery", int'(state_o), S_BATT);
        chk("R9 batt_sel", int'(batt_sel), 1);
        vcc_above_sw = 1'b1;
        step(8);
        chk("R9 back to fail", int'(state_o), S_FAIL);
        vcc_ok_hi = 1'b1;
        step(8);
        chk("R9 then recover", int'(state_o), S_REC);
        step(45);
        rst_n = 1'b0;
        step(2);
        chk("R11 armed kept in reset", int'(batt_armed), 1);
        rst_n = 1'b1;
        step(60);
        chk("R11 normal again", int'(state_o), S_NORMAL);
        seal_clr_n = 1'b0;
        step(2);
        chk("R11 seal clear", int'(batt_armed), 0);
        chk("R1 sealed on clear", int'(state_o), S_SEALED);
        seal_clr_n = 1'b1;
        step(10);
        chk("R4 re-armed", int'(batt_armed), 1);
        step(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule